// File: doc/BRIEF.md
# PCI DMA Window Translator

This block turns a DMA bus address arriving from the PCI side into a system memory address. Four programmable windows cover the 32-bit (single-address-cycle) space. Each window either maps its span linearly onto a translated base, or fetches a page-table entry from memory and builds the result from that entry. A hole in the low megabyte can be switched on to block all matching there. For 64-bit (double-address-cycle) addresses there are two further paths. A flat pass-through range copies the low 35 bits. A second scatter-gather path runs through the last window when that window's double-address-cycle enable is set.

Software loads the windows through a small indexed register port that writes synchronously and reads combinationally. The translator takes one request at a time and stays busy until it returns a single-cycle result. The result is a translated address or a fault. When a page-table entry is needed, the translator issues one 64-bit read on a request/acknowledge handshake and waits for the data.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset every register reads zero, except the window-3 base register, which reads 0x2.
- R2: Writes keep only the implemented bits. Base registers of windows 0..2 use mask 0xFFF0_0003: bit 0 is enable and bit 1 is scatter-gather. The window-3 base uses mask 0x80_FFF0_0001 and always reads bit 1 as 1; its bit 39 is the double-address-cycle enable. Mask registers use 0xFFF0_0000. Translated-base registers use 0x7_FFFF_FC00. The control register uses 0x1C_FF0F_C7FF, where bit 5 is the hole enable and bit 6 is the pass-through enable. Register index map: 0..3 base, 4..7 mask, 8..11 translated base, 12 control; any other index reads zero and ignores writes.
- R3: A window matches an address at or below 0xFFFF_FFFF when its enable bit is set and the address ANDed with NOT(mask OR 0xFFFFF) equals the base ANDed with 0xFFF0_0000.
- R4: A matching direct window returns (tbase AND NOT e) OR (addr AND e), where e = mask OR 0xFFFFF.
- R5: A matching scatter-gather window reads the entry at (tbase AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). An entry with bit 0 clear gives a fault. A valid entry gives ((entry AND 0x3FFFFE)<<12) OR (addr AND 0x1FFF).
- R6: When control bit 5 is set, single-cycle addresses 0x80000..0xFFFFF fault even if a window covers them.
- R7: Among single-cycle matches, the lowest-numbered window wins. Window 3 takes part only while its bit 39 is clear.
- R8: With control bit 6 set, addresses in [0x100_0000_0000, 0x200_0000_0000) return addr AND 0x7_FFFF_FFFF without any memory read.
- R9: Addresses in 0x800_0000_0000..0xFFF_FFFF_FFFF, when window-3 bits 39 and 0 are both set, read the entry at (tbase3 AND 0x7_FFC0_0000) OR ((addr AND 0xFFFF_E000)>>10). That entry is checked and converted as in R5.
- R10: A request is taken only while busy is low. Busy rises the next cycle. A result without a memory read appears two cycles after acceptance. For a memory read, the read request rises two cycles after acceptance and holds with a stable address until acknowledged, and the result appears the cycle after the acknowledge. The result valid lasts one cycle, and requests made while busy are ignored.
- R11: A miss, a 64-bit address outside the enabled ranges, or an invalid entry returns a fault with a zero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_idx |
| req_valid | input | 1 | Translation request |
| req_addr | input | ADDR_W | Bus address to translate |
| busy | output | 1 | Translation in progress |
| mem_req | output | 1 | Page-table entry read request |
| mem_addr | output | 64 | Page-table entry address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_data | input | DATA_W | Page-table entry data |
| res_valid | output | 1 | Result strobe |
| res_fault | output | 1 | Translation failed |
| res_addr | output | 64 | Translated system address |

## Verification
Some rules are checked by assertions on every cycle. The read request must hold its address until acknowledged. The result strobe lasts one cycle and frees the block. A fault always carries a zero address. Hole addresses never translate, and pass-through results equal the masked input. Other behaviours only show up in the bench's scenarios against its behavioural model. These are the register masks and reset values, window priority, the bit-39 gating of window 3 in both address modes, the exact entry address formulas, and invalid-entry faults.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
   localparam logic [63:0] BASE_WMASK      = 64'h0000_0000_FFF0_0003;
   localparam logic [63:0] BASE_LAST_WMASK = 64'h0000_0080_FFF0_0001;
   localparam logic [63:0] BASE_LAST_SET   = 64'h0000_0000_0000_0002;
   localparam logic [63:0] MASK_WMASK      = 64'h0000_0000_FFF0_0000;
   localparam logic [63:0] TBASE_WMASK     = 64'h0000_0007_FFFF_FC00;
   localparam logic [63:0] CTL_WMASK       = 64'h0000_001C_FF0F_C7FF;
   localparam logic [63:0] WIN_GRAIN       = 64'h0000_0000_000F_FFFF;
   localparam logic [63:0] SG_IDX_BITS     = 64'h0000_0000_000F_E000;
   localparam logic [63:0] PTE_PFN_MASK    = 64'h0000_0000_003F_FFFE;
   localparam logic [63:0] PAGE_OFS_MASK   = 64'h0000_0000_0000_1FFF;
   localparam logic [63:0] PASS_KEEP       = 64'h0000_0007_FFFF_FFFF;
   localparam logic [63:0] DAC_TB_MASK     = 64'h0000_0007_FFC0_0000;
   localparam logic [63:0] DAC_IDX_MASK    = 64'h0000_0000_FFFF_E000;
   localparam int BIT_EN    = 0;
   localparam int BIT_SG    = 1;
   localparam int BIT_DAC   = 39;
   localparam int CTL_HOLE  = 5;
   localparam int CTL_PASS  = 6;

   typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_FETCH, ST_RESP} xl_state_e;
endpackage

// File: rtl/dwx_regfile.sv
module dwx_regfile import dwx_pkg::*; #(
   parameter int NWIN  = 4,
   parameter int IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       idx,
   input  logic [63:0]            wdata,
   output logic [63:0]            rdata,
   output logic [NWIN-1:0][63:0]  base,
   output logic [NWIN-1:0][63:0]  mask,
   output logic [NWIN-1:0][63:0]  tbase,
   output logic [63:0]            ctl
);
   localparam int MASK_IDX  = NWIN;
   localparam int TBASE_IDX = 2 * NWIN;
   localparam int CTL_IDX   = 3 * NWIN;

   logic [NWIN-1:0][63:0] base_q, mask_q, tbase_q;
   logic [63:0]           ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         tbase_q <= '0;
         ctl_q   <= '0;
         base_q[NWIN-1] <= BASE_LAST_SET;
      end else if (wr_en) begin
         for (int i = 0; i < NWIN; i++) begin
            if (idx == IDX_W'(i)) begin
               if (i == NWIN - 1)
                  base_q[i] <= (wdata & BASE_LAST_WMASK) | BASE_LAST_SET;
               else
                  base_q[i] <= wdata & BASE_WMASK;
            end
            if (idx == IDX_W'(MASK_IDX + i))
               mask_q[i] <= wdata & MASK_WMASK;
            if (idx == IDX_W'(TBASE_IDX + i))
               tbase_q[i] <= wdata & TBASE_WMASK;
         end
         if (idx == IDX_W'(CTL_IDX))
            ctl_q <= wdata & CTL_WMASK;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (idx == IDX_W'(i))             rdata = base_q[i];
         if (idx == IDX_W'(MASK_IDX + i))  rdata = mask_q[i];
         if (idx == IDX_W'(TBASE_IDX + i)) rdata = tbase_q[i];
      end
      if (idx == IDX_W'(CTL_IDX)) rdata = ctl_q;
   end

   assign base  = base_q;
   assign mask  = mask_q;
   assign tbase = tbase_q;
   assign ctl   = ctl_q;
endmodule

// File: rtl/dwx_window.sv
module dwx_window import dwx_pkg::*; #(
   parameter bit GATE_DAC = 1'b0
) (
   input  logic [31:0] addr,
   input  logic [63:0] base,
   input  logic [63:0] mask,
   input  logic [63:0] tbase,
   output logic        hit,
   output logic        sg,
   output logic [63:0] direct_addr,
   output logic [63:0] pte_addr
);
   logic [63:0] a64, ext;
   logic        raw_hit;

   assign a64     = {32'h0, addr};
   assign ext     = mask | WIN_GRAIN;
   assign raw_hit = base[BIT_EN] && ((a64 & ~ext) == (base & MASK_WMASK));
   assign sg      = base[BIT_SG];

   generate
      if (GATE_DAC) begin : g_gated
         assign hit = raw_hit && !base[BIT_DAC];
      end else begin : g_plain
         assign hit = raw_hit;
      end
   endgenerate

   assign direct_addr = (tbase & ~ext) | (a64 & ext);
   assign pte_addr    = (tbase & ~(mask >> 10)) | ((a64 & (mask | SG_IDX_BITS)) >> 10);
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate import dwx_pkg::*; #(
   parameter int NWIN   = 4,
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              mem_req,
   output logic [63:0]       mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_data,
   output logic              res_valid,
   output logic              res_fault,
   output logic [63:0]       res_addr
);
   localparam int LAST = NWIN - 1;

   generate
      if (NWIN != 4) begin : g_bad_nwin
         $error("dma_win_xlate: NWIN must be 4");
      end
      if (3 * NWIN + 1 > (1 << IDX_W)) begin : g_bad_idx
         $error("dma_win_xlate: IDX_W too small for register map");
      end
      if (ADDR_W < 44 || ADDR_W > 64) begin : g_bad_addr
         $error("dma_win_xlate: ADDR_W must be 44..64");
      end
      if (DATA_W != 64) begin : g_bad_data
         $error("dma_win_xlate: DATA_W must be 64");
      end
   endgenerate

   logic [NWIN-1:0][63:0] base, mask, tbase;
   logic [63:0]           ctl;

   dwx_regfile #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .idx(reg_idx),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .base(base), .mask(mask), .tbase(tbase), .ctl(ctl)
   );

   xl_state_e         state;
   logic [ADDR_W-1:0] addr_q;
   logic [63:0]       a64, pte_q, res_addr_q;
   logic              res_fault_q;

   assign a64 = 64'(addr_q);

   logic [NWIN-1:0]       win_hit, win_sg;
   logic [NWIN-1:0][63:0] win_direct, win_pte;

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         dwx_window #(.GATE_DAC(w == LAST)) u_win (
            .addr(a64[31:0]), .base(base[w]), .mask(mask[w]), .tbase(tbase[w]),
            .hit(win_hit[w]), .sg(win_sg[w]),
            .direct_addr(win_direct[w]), .pte_addr(win_pte[w])
         );
      end
   endgenerate

   logic        sel_hit, sel_sg;
   logic [63:0] sel_direct, sel_pte;

   always_comb begin
      sel_hit = 1'b0; sel_sg = 1'b0; sel_direct = '0; sel_pte = '0;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (win_hit[w]) begin
            sel_hit    = 1'b1;
            sel_sg     = win_sg[w];
            sel_direct = win_direct[w];
            sel_pte    = win_pte[w];
         end
      end
   end

   logic is_sac, in_hole, in_pass, in_dsg;
   logic [63:0] dac_pte;

   assign is_sac  = (a64[63:32] == 32'h0);
   assign in_hole = is_sac && (a64[31:0] >= 32'h0008_0000) && (a64[31:0] <= 32'h000F_FFFF);
   assign in_pass = (a64 >= 64'h0000_0100_0000_0000) && (a64 < 64'h0000_0200_0000_0000);
   assign in_dsg  = (a64 >= 64'h0000_0800_0000_0000) && (a64 <= 64'h0000_0FFF_FFFF_FFFF);
   assign dac_pte = (tbase[LAST] & DAC_TB_MASK) | ((a64 & DAC_IDX_MASK) >> 10);

   logic        dec_fault, dec_fetch;
   logic [63:0] dec_val;

   always_comb begin
      dec_fault = 1'b1; dec_fetch = 1'b0; dec_val = '0;
      if (is_sac) begin
         if (!(ctl[CTL_HOLE] && in_hole) && sel_hit) begin
            dec_fault = 1'b0;
            dec_fetch = sel_sg;
            dec_val   = sel_sg ? sel_pte : sel_direct;
         end
      end else if (in_pass && ctl[CTL_PASS]) begin
         dec_fault = 1'b0;
         dec_val   = a64 & PASS_KEEP;
      end else if (in_dsg && base[LAST][BIT_DAC] && base[LAST][BIT_EN]) begin
         dec_fault = 1'b0;
         dec_fetch = 1'b1;
         dec_val   = dac_pte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         addr_q      <= '0;
         pte_q       <= '0;
         res_fault_q <= 1'b0;
         res_addr_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               addr_q <= req_addr;
               state  <= ST_EVAL;
            end
            ST_EVAL: begin
               if (dec_fetch) begin
                  pte_q <= dec_val;
                  state <= ST_FETCH;
               end else begin
                  res_fault_q <= dec_fault;
                  res_addr_q  <= dec_fault ? 64'h0 : dec_val;
                  state       <= ST_RESP;
               end
            end
            ST_FETCH: if (mem_ack) begin
               state <= ST_RESP;
               if (mem_data[BIT_EN]) begin
                  res_fault_q <= 1'b0;
                  res_addr_q  <= ((64'(mem_data) & PTE_PFN_MASK) << 12) | (a64 & PAGE_OFS_MASK);
               end else begin
                  res_fault_q <= 1'b1;
                  res_addr_q  <= '0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign mem_req   = (state == ST_FETCH);
   assign mem_addr  = pte_q;
   assign res_valid = (state == ST_RESP);
   assign res_fault = res_fault_q;
   assign res_addr  = res_addr_q;

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
   p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid && !busy);
   p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |-> res_addr == 64'h0);
   p_hole_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && ctl[CTL_HOLE] && in_hole |-> res_fault);
   p_pass_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault && in_pass |-> res_addr == (a64 & PASS_KEEP));
   p_req_needs_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy && !res_valid);
endmodule

// File: tb/dma_win_xlate_bench.sv
module dma_win_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        busy, mem_req, mem_ack = 1'b0;
   logic [63:0] mem_addr, mem_data = '0;
   logic        res_valid, res_fault;
   logic [63:0] res_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] sh_base[4], sh_mask[4], sh_tbase[4], sh_ctl;

   always #2 clk = ~clk;

   dma_win_xlate u_dma_win_xlate (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .res_valid(res_valid), .res_fault(res_fault), .res_addr(res_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [63:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
      if (idx < 3)       sh_base[idx] = v & 64'hFFF0_0003;
      else if (idx == 3) sh_base[3] = (v & 64'h80_FFF0_0001) | 64'h2;
      else if (idx < 8)  sh_mask[idx-4] = v & 64'hFFF0_0000;
      else if (idx < 12) sh_tbase[idx-8] = v & 64'h7_FFFF_FC00;
      else if (idx == 12) sh_ctl = v & 64'h1C_FF0F_C7FF;
   endtask

   task automatic rd_chk(input string tag, input int idx, input logic [63:0] exp);
      @(negedge clk);
      reg_idx = 4'(idx);
      #1 chk(tag, reg_rdata, exp);
   endtask

   // behavioural model: fault, fetch needed, value (result or entry address)
   task automatic model(input logic [63:0] a, output bit flt, output bit fet,
                        output logic [63:0] val);
      logic [63:0] ext;
      flt = 1'b1; fet = 1'b0; val = '0;
      if (a <= 64'hFFFF_FFFF) begin
         if (sh_ctl[5] && a >= 64'h8_0000 && a <= 64'hF_FFFF) return;
         for (int w = 0; w < 4; w++) begin
            if (w == 3 && sh_base[3][39]) continue;
            if (!sh_base[w][0]) continue;
            ext = sh_mask[w] | 64'hF_FFFF;
            if ((a & ~ext) != (sh_base[w] & 64'hFFF0_0000)) continue;
            flt = 1'b0;
            if (sh_base[w][1]) begin
               fet = 1'b1;
               val = (sh_tbase[w] & ~(sh_mask[w] >> 10)) | ((a & (sh_mask[w] | 64'hF_E000)) >> 10);
            end else begin
               val = (sh_tbase[w] & ~ext) | (a & ext);
            end
            return;
         end
      end else if (a >= 64'h100_0000_0000 && a < 64'h200_0000_0000 && sh_ctl[6]) begin
         flt = 1'b0; val = a & 64'h7_FFFF_FFFF;
      end else if (a >= 64'h800_0000_0000 && a <= 64'hFFF_FFFF_FFFF
                   && sh_base[3][39] && sh_base[3][0]) begin
         flt = 1'b0; fet = 1'b1;
         val = (sh_tbase[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
      end
   endtask

   task automatic xact(input string tag, input logic [63:0] a, input logic [63:0] pte,
                       input int dly);
      bit flt, fet;
      logic [63:0] val, exp_addr;
      bit exp_flt;
      model(a, flt, fet, val);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R10 busy after accept"}, 64'(busy), 64'h1);
      exp_flt = flt; exp_addr = flt ? 64'h0 : val;
      if (fet) begin
         @(negedge clk);
         chk({tag, " R10 mem_req"}, 64'(mem_req), 64'h1);
         chk({tag, " entry address"}, mem_addr, val);
         for (int i = 0; i < dly; i++) begin
            req_valid = 1'b1; req_addr = 64'h4000_0000 + 64'(i);
            @(negedge clk);
            req_valid = 1'b0;
            chk({tag, " R10 mem_req held"}, 64'(mem_req), 64'h1);
            chk({tag, " R10 mem_addr stable"}, mem_addr, val);
         end
         mem_ack = 1'b1; mem_data = pte;
         if (pte[0]) begin
            exp_flt = 1'b0;
            exp_addr = ((pte & 64'h3F_FFFE) << 12) | (a & 64'h1FFF);
         end else begin
            exp_flt = 1'b1; exp_addr = 64'h0;
         end
         @(negedge clk);
         mem_ack = 1'b0;
      end else begin
         @(negedge clk);
      end
      chk({tag, " R10 res_valid"}, 64'(res_valid), 64'h1);
      chk({tag, " fault"}, 64'(res_fault), 64'(exp_flt));
      chk({tag, " address"}, res_addr, exp_addr);
      @(negedge clk);
      chk({tag, " R10 one-cycle result"}, 64'({res_valid, busy}), 64'h0);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         sh_base[i] = '0; sh_mask[i] = '0; sh_tbase[i] = '0;
      end
      sh_base[3] = 64'h2; sh_ctl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      for (int i = 0; i < 13; i++) rd_chk("R1 reset", i, (i == 3) ? 64'h2 : 64'h0);
      chk("R1 idle outputs", 64'({busy, mem_req, res_valid}), 64'h0);
      // R2 write masks
      wr(0, '1);  rd_chk("R2 base0 mask", 0, 64'hFFF0_0003);
      wr(3, '1);  rd_chk("R2 base3 mask", 3, 64'h80_FFF0_0003);
      wr(3, 64'h0); rd_chk("R2 base3 bit1 forced", 3, 64'h2);
      wr(5, '1);  rd_chk("R2 mask1", 5, 64'hFFF0_0000);
      wr(9, '1);  rd_chk("R2 tbase1", 9, 64'h7_FFFF_FC00);
      wr(12, '1); rd_chk("R2 ctl", 12, 64'h1C_FF0F_C7FF);
      wr(13, '1); rd_chk("R2 unmapped", 13, 64'h0);
      wr(0, 0); wr(5, 0); wr(9, 0); wr(12, 0);
      // R3 R4 direct window 0
      wr(0, 64'h4000_0001); wr(4, 64'h0FF0_0000); wr(8, 64'h1_2000_0000);
      xact("R3 R4 direct hit", 64'h4123_4567, 0, 0);
      xact("R3 R11 miss", 64'h5000_0000, 0, 0);
      // R5 scatter-gather window 1
      wr(1, 64'h8000_0003); wr(9, 64'h2_0000_0000);
      xact("R5 sg valid", 64'h8001_2345, 64'h12_3401, 2);
      xact("R5 R11 sg invalid", 64'h8001_2345, 64'h12_3400, 0);
      // R7 priority
      wr(2, 64'h4000_0001); wr(10, 64'h3_0000_0000);
      xact("R7 window0 wins", 64'h4000_0010, 0, 0);
      wr(0, 64'h0);
      xact("R7 window2 after window0 off", 64'h4000_0010, 0, 0);
      wr(3, 64'hC000_0001); wr(11, 64'h3_4000_0000);
      xact("R7 window3 sac", 64'hC000_4000, 64'h55_5551, 1);
      wr(3, 64'h80_C000_0001);
      xact("R7 window3 gated", 64'hC000_4000, 0, 0);
      // R9 dac scatter-gather
      xact("R9 dac sg", 64'h800_1234_5678, 64'h3F_FFFF, 0);
      xact("R9 R11 dac above range", 64'h1000_0000_0000, 0, 0);
      // R8 pass-through
      xact("R8 R11 pass disabled", 64'h1AB_CDEF_1234, 0, 0);
      wr(12, 64'h40);
      xact("R8 pass enabled", 64'h1AB_CDEF_1234, 0, 0);
      // R6 hole
      wr(0, 64'h0000_0001); wr(4, 64'h0FF0_0000); wr(8, 64'h0);
      wr(12, 64'h20);
      xact("R6 hole blocks", 64'h9_0000, 0, 0);
      xact("R6 below hole", 64'h7_FFFF, 0, 0);
      wr(12, 64'h0);
      xact("R6 hole off", 64'h9_0000, 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule